// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a flat physical address. It holds a small table with one entry per segment. Each entry stores a base address, a limit, a shareable attribute and a valid flag. On every request the offset is compared against the selected segment's limit. An offset below the limit yields base plus offset. Any other case raises a trap, and the trap carries a cause code.

The table is loaded through a simple write port. One entry is written per cycle, and a write may also mark an entry invalid. Requests are presented with a strobe. The result is registered and appears one clock later as either an address-valid strobe or a trap strobe, never both. Software above the block decides what a trap means. The block only reports the fault and produces no address for it.

Top module: `seg_xlate`

## Requirements
- R1: A request is taken when `req_valid` is high. Its result appears on the outputs in the next cycle, one cycle of latency. In a cycle after one with no request, `out_valid` and `out_trap` are both low.
- R2: A write with `tbl_we` high stores base, limit, shareable bit and valid flag into entry `tbl_idx`. The new contents are used by requests from the following cycle on. A request in the same cycle as a write to its own segment is translated with the entry's previous contents.
- R3: When the segment number is in range, the entry is valid and the offset is strictly less than the limit, `out_valid` rises, `out_cause` is 0 and `out_paddr` equals base plus offset, zero-extended to the output width.
- R4: When the offset is greater than or equal to the limit, the result is a trap with `out_cause` = 3. A limit of zero therefore rejects every offset.
- R5: A segment number greater than or equal to `SEG_COUNT` traps with `out_cause` = 1. A table write whose index is greater than or equal to `SEG_COUNT` changes no entry.
- R6: A reference to an entry whose valid flag is clear traps with `out_cause` = 2. Reset clears every valid flag. The trap causes are prioritised range (1) over invalid (2) over limit (3).
- R7: `out_valid` and `out_trap` are never high together. While `out_trap` is high, `out_paddr` is 0 and `out_share` is 0.
- R8: On a successful translation `out_share` reports the shareable bit stored in the selected entry.
- R9: While reset is held, and in the cycle after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | SEGNUM_W | Entry index to write |
| tbl_base | input | BASE_W | Base address to store |
| tbl_limit | input | OFF_W+1 | Segment length to store |
| tbl_share | input | 1 | Shareable attribute to store |
| tbl_valid | input | 1 | Valid flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | SEGNUM_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| out_valid | output | 1 | Physical address is valid |
| out_trap | output | 1 | Request faulted |
| out_cause | output | 2 | 0 none, 1 range, 2 invalid entry, 3 beyond limit |
| out_paddr | output | max(BASE_W,OFF_W)+1 | Translated physical address |
| out_share | output | 1 | Shareable bit of the translated segment |

## Verification
The assertions check on every cycle that the two result strobes are exclusive and that exactly one of them follows each request. They also check that an idle cycle yields neither strobe, that a trap carries a zero address and a non-zero cause, and that an out-of-range segment number always traps with the range cause. Inside the table they check that a write lands in the addressed entry, that a write to a non-existent index changes no valid flag, and that reset empties the table. The actual arithmetic, the strict comparison at offset equal to limit, and the cause priority depend on stored table contents. So do the same-cycle write/read ordering and the shareable attribute. Only the bench's reference model shows these, through directed scenarios on the sample table and a randomised mix of writes and requests.

// File: rtl/seg_xlate_pkg.sv
// Package: shared encodings of the segment translator.
// Assumes: nothing; holds only types used by several modules.
package seg_xlate_pkg;

    // Reason a request was refused; NONE means a good translation.
    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_RANGE   = 2'd1,
        CAUSE_INVALID = 2'd2,
        CAUSE_LIMIT   = 2'd3
    } fault_cause_e;

endpackage

// File: rtl/seg_table.sv
// Module: seg_table
// Holds one base/limit/attribute/valid record per segment. It has one
// synchronous write port and one combinational read port.
// Assumes: SEG_COUNT <= 2**SEGNUM_W. Writes to indices at or above
// SEG_COUNT are dropped. A read of such an index returns an all-zero record
// with rd_hit low.
module seg_table #(
    parameter int SEG_COUNT = 6,
    parameter int SEGNUM_W  = 4,
    parameter int LIM_W     = 13,
    parameter int BASE_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEGNUM_W-1:0] wr_idx,
    input  logic [BASE_W-1:0]   wr_base,
    input  logic [LIM_W-1:0]    wr_limit,
    input  logic                wr_share,
    input  logic                wr_valid,
    input  logic [SEGNUM_W-1:0] rd_idx,
    output logic                rd_hit,
    output logic                rd_valid,
    output logic [BASE_W-1:0]   rd_base,
    output logic [LIM_W-1:0]    rd_limit,
    output logic                rd_share
);

    localparam logic [SEGNUM_W:0] COUNT_L = (SEGNUM_W+1)'(SEG_COUNT);

    logic [BASE_W-1:0]    ent_base  [SEG_COUNT];
    logic [LIM_W-1:0]     ent_limit [SEG_COUNT];
    logic [SEG_COUNT-1:0] ent_share;
    logic [SEG_COUNT-1:0] ent_valid;

    // One storage slice per segment; each decodes its own write select.
    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == SEGNUM_W'(g));

        // Purpose: clear valid on reset, otherwise capture a write aimed here.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
                ent_share[g] <= 1'b0;
                ent_base[g]  <= '0;
                ent_limit[g] <= '0;
            end else if (sel) begin
                ent_valid[g] <= wr_valid;
                ent_share[g] <= wr_share;
                ent_base[g]  <= wr_base;
                ent_limit[g] <= wr_limit;
            end
        end
    end

    // Purpose: flag whether the read index names an existing entry.
    always_comb begin
        rd_hit = ({1'b0, rd_idx} < COUNT_L);
    end

    // Purpose: select the addressed record, zero when the index is out of range.
    always_comb begin
        rd_valid = 1'b0;
        rd_share = 1'b0;
        rd_base  = '0;
        rd_limit = '0;
        for (int i = 0; i < SEG_COUNT; i++) begin
            if (rd_idx == SEGNUM_W'(i)) begin
                rd_valid = ent_valid[i];
                rd_share = ent_share[i];
                rd_base  = ent_base[i];
                rd_limit = ent_limit[i];
            end
        end
    end

    // R2: a write to an existing entry is visible in that entry next cycle.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} < COUNT_L))
        |=> (ent_base[$past(wr_idx)] == $past(wr_base))
            && (ent_limit[$past(wr_idx)] == $past(wr_limit))
            && (ent_valid[$past(wr_idx)] == $past(wr_valid)));

    // R5: a write to an index past the table leaves every valid flag alone.
    assert_bad_index_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} >= COUNT_L)) |=> $stable(ent_valid));

    // R6: reset leaves the table with no valid entry.
    assert_reset_clears_R6: assert property (@(posedge clk)
        !rst_n |=> (ent_valid == '0));

endmodule

// File: rtl/seg_check.sv
// Module: seg_check
// Combinational protection and relocation stage. It decides whether a
// reference is legal and, if so, adds the segment base to the offset.
// Assumes: LIM_W = OFF_W + 1 so a limit can cover every offset. PA_W is wide
// enough that base + offset never wraps.
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int LIM_W  = 13,
    parameter int BASE_W = 16,
    parameter int PA_W   = 17
) (
    input  logic              seg_hit,
    input  logic              ent_valid,
    input  logic [BASE_W-1:0] ent_base,
    input  logic [LIM_W-1:0]  ent_limit,
    input  logic              ent_share,
    input  logic [OFF_W-1:0]  offset,
    output logic              pass,
    output fault_cause_e      cause,
    output logic [PA_W-1:0]   paddr,
    output logic              share
);

    logic            in_bounds;
    logic [PA_W-1:0] sum;

    // Purpose: strict less-than bounds test of the offset against the limit.
    always_comb begin
        in_bounds = ({1'b0, offset} < ent_limit);
    end

    // Purpose: relocation adder, widened so the carry is kept.
    always_comb begin
        sum = PA_W'(ent_base) + PA_W'(offset);
    end

    // Purpose: pick the fault with priority range > invalid > limit.
    always_comb begin
        if (!seg_hit)        cause = CAUSE_RANGE;
        else if (!ent_valid) cause = CAUSE_INVALID;
        else if (!in_bounds) cause = CAUSE_LIMIT;
        else                 cause = CAUSE_NONE;
    end

    // Purpose: release address and attribute only for a legal reference.
    always_comb begin
        pass  = (cause == CAUSE_NONE);
        paddr = pass ? sum : '0;
        share = pass && ent_share;
    end

endmodule

// File: rtl/seg_xlate.sv
// Module: seg_xlate (top)
// Segment-table translator. A (segment, offset) request is looked up in
// seg_table and checked and relocated in seg_check. The result is registered,
// so the outputs follow the request by one cycle.
// Assumes: synchronous active-low reset. A table write and a request in the
// same cycle see the table as it was before that write.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_COUNT = 6,
    parameter int SEGNUM_W  = 4,
    parameter int OFF_W     = 12,
    parameter int BASE_W    = 16,
    localparam int LIM_W    = OFF_W + 1,
    localparam int PA_W     = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_we,
    input  logic [SEGNUM_W-1:0] tbl_idx,
    input  logic [BASE_W-1:0]   tbl_base,
    input  logic [LIM_W-1:0]    tbl_limit,
    input  logic                tbl_share,
    input  logic                tbl_valid,
    input  logic                req_valid,
    input  logic [SEGNUM_W-1:0] req_seg,
    input  logic [OFF_W-1:0]    req_off,
    output logic                out_valid,
    output logic                out_trap,
    output logic [1:0]          out_cause,
    output logic [PA_W-1:0]     out_paddr,
    output logic                out_share
);

    localparam logic [SEGNUM_W:0] COUNT_L = (SEGNUM_W+1)'(SEG_COUNT);

    logic              rd_hit;
    logic              rd_valid;
    logic [BASE_W-1:0] rd_base;
    logic [LIM_W-1:0]  rd_limit;
    logic              rd_share;
    logic              chk_pass;
    fault_cause_e      chk_cause;
    logic [PA_W-1:0]   chk_paddr;
    logic              chk_share;

    seg_table #(
        .SEG_COUNT (SEG_COUNT),
        .SEGNUM_W  (SEGNUM_W),
        .LIM_W     (LIM_W),
        .BASE_W    (BASE_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_base  (tbl_base),
        .wr_limit (tbl_limit),
        .wr_share (tbl_share),
        .wr_valid (tbl_valid),
        .rd_idx   (req_seg),
        .rd_hit   (rd_hit),
        .rd_valid (rd_valid),
        .rd_base  (rd_base),
        .rd_limit (rd_limit),
        .rd_share (rd_share)
    );

    seg_check #(
        .OFF_W  (OFF_W),
        .LIM_W  (LIM_W),
        .BASE_W (BASE_W),
        .PA_W   (PA_W)
    ) u_check (
        .seg_hit   (rd_hit),
        .ent_valid (rd_valid),
        .ent_base  (rd_base),
        .ent_limit (rd_limit),
        .ent_share (rd_share),
        .offset    (req_off),
        .pass      (chk_pass),
        .cause     (chk_cause),
        .paddr     (chk_paddr),
        .share     (chk_share)
    );

    // Purpose: register the translation result, or clear it when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            out_valid <= 1'b0;
            out_trap  <= 1'b0;
            out_cause <= 2'd0;
            out_paddr <= '0;
            out_share <= 1'b0;
        end else begin
            out_valid <= chk_pass;
            out_trap  <= !chk_pass;
            out_cause <= chk_cause;
            out_paddr <= chk_paddr;
            out_share <= chk_share;
        end
    end

    // R7: the address strobe and the trap strobe exclude each other.
    assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_trap));

    // R1: every request yields exactly one strobe in the next cycle.
    assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_valid != out_trap));

    // R1: an idle cycle yields no strobe in the next cycle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_trap));

    // R7: a trap carries no address, no attribute and a non-zero cause.
    assert_trap_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_paddr == '0) && !out_share && (out_cause != 2'd0));

    // R5: a segment number past the table always traps with the range cause.
    assert_range_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= COUNT_L))
        |=> (out_trap && (out_cause == 2'd1)));

    // R9: the cycle after reset shows all outputs zero.
    assert_reset_outputs_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_trap && (out_cause == 2'd0)
                    && (out_paddr == '0) && !out_share));

endmodule

// File: tb/seg_xlate_tb.sv
// Bench for seg_xlate. A behavioural reference model (integer arrays)
// predicts the registered outputs each clock and compares them at the falling edge.
module seg_xlate_tb;

    localparam int SEG_COUNT = 6;
    localparam int SEGNUM_W  = 4;
    localparam int OFF_W     = 12;
    localparam int BASE_W    = 16;
    localparam int LIM_W     = OFF_W + 1;
    localparam int PA_W      = BASE_W + 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                tbl_we = 1'b0;
    logic [SEGNUM_W-1:0] tbl_idx = '0;
    logic [BASE_W-1:0]   tbl_base = '0;
    logic [LIM_W-1:0]    tbl_limit = '0;
    logic                tbl_share = 1'b0;
    logic                tbl_valid = 1'b0;
    logic                req_valid = 1'b0;
    logic [SEGNUM_W-1:0] req_seg = '0;
    logic [OFF_W-1:0]    req_off = '0;
    logic                out_valid;
    logic                out_trap;
    logic [1:0]          out_cause;
    logic [PA_W-1:0]     out_paddr;
    logic                out_share;

    seg_xlate #(
        .SEG_COUNT (SEG_COUNT),
        .SEGNUM_W  (SEGNUM_W),
        .OFF_W     (OFF_W),
        .BASE_W    (BASE_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit),
        .tbl_share (tbl_share),
        .tbl_valid (tbl_valid),
        .req_valid (req_valid),
        .req_seg   (req_seg),
        .req_off   (req_off),
        .out_valid (out_valid),
        .out_trap  (out_trap),
        .out_cause (out_cause),
        .out_paddr (out_paddr),
        .out_share (out_share)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    int m_base [SEG_COUNT];
    int m_lim  [SEG_COUNT];
    bit m_sh   [SEG_COUNT];
    bit m_v    [SEG_COUNT];
    bit    e_valid, e_trap, e_share;
    int    e_cause, e_paddr;
    string e_tag = "R9";

    // Model: predict next registered result from inputs and old table, then apply write.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 0; e_trap = 0; e_share = 0; e_cause = 0; e_paddr = 0;
            e_tag = "R9";
            for (int i = 0; i < SEG_COUNT; i++) m_v[i] = 0;
        end else begin
            e_valid = 0; e_trap = 0; e_share = 0; e_cause = 0; e_paddr = 0;
            e_tag = "R1";
            if (req_valid) begin
                int s;
                s = int'(req_seg);
                if (s >= SEG_COUNT) begin
                    e_trap = 1; e_cause = 1; e_tag = "R5";
                end else if (!m_v[s]) begin
                    e_trap = 1; e_cause = 2; e_tag = "R6";
                end else if (int'(req_off) >= m_lim[s]) begin
                    e_trap = 1; e_cause = 3; e_tag = "R4";
                end else begin
                    e_valid = 1; e_paddr = m_base[s] + int'(req_off);
                    e_share = m_sh[s];
                    e_tag = m_sh[s] ? "R8" : "R3";
                end
                if (tbl_we && tbl_idx == req_seg) e_tag = "R2";
            end
            if (tbl_we && int'(tbl_idx) < SEG_COUNT) begin
                m_base[tbl_idx] = int'(tbl_base);
                m_lim[tbl_idx]  = int'(tbl_limit);
                m_sh[tbl_idx]   = tbl_share;
                m_v[tbl_idx]    = tbl_valid;
            end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            n_cmp++;
            if (out_valid !== e_valid || out_trap !== e_trap || int'(out_cause) != e_cause
                || int'(out_paddr) != e_paddr || out_share !== e_share) begin
                n_bad++;
                $display("FAIL %s: act v=%0b t=%0b c=%0d pa=%0d sh=%0b exp v=%0b t=%0b c=%0d pa=%0d sh=%0b",
                         e_tag, out_valid, out_trap, out_cause, out_paddr, out_share,
                         e_valid, e_trap, e_cause, e_paddr, e_share);
            end
            n_cmp++;
            if (out_valid && out_trap) begin
                n_bad++;
                $display("FAIL R7: act both strobes high exp at most one");
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        tbl_we = 0; req_valid = 0;
    endtask

    task automatic wr(input int idx, input int base, input int lim, input bit sh, input bit v);
        @(negedge clk);
        req_valid = 0;
        tbl_we = 1; tbl_idx = SEGNUM_W'(idx); tbl_base = BASE_W'(base);
        tbl_limit = LIM_W'(lim); tbl_share = sh; tbl_valid = v;
    endtask

    task automatic rq(input int seg, input int off);
        @(negedge clk);
        tbl_we = 0;
        req_valid = 1; req_seg = SEGNUM_W'(seg); req_off = OFF_W'(off);
    endtask

    task automatic load_sample();
        wr(0, 1400, 1000, 0, 1);
        wr(1, 6300, 400, 0, 1);
        wr(2, 4300, 400, 1, 1);
        wr(3, 3200, 1100, 0, 1);
        wr(4, 4700, 1000, 1, 1);
        wr(5, 100, 0, 0, 1);
        idle();
    endtask

    initial begin
        @(posedge clk);
        cmp_en = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R9 and R6: after reset the table is empty
        rq(0, 0); rq(3, 5); idle();
        load_sample();
        // R3: legal references on the sample table
        rq(2, 53); rq(3, 852); rq(0, 999); rq(1, 0);
        // R4: offset equal to and beyond the limit; limit of zero
        rq(0, 1000); rq(1, 400); rq(3, 4095); rq(5, 0);
        // R8: shareable segment
        rq(4, 0); rq(2, 399);
        // R5: segment numbers past the table
        rq(6, 0); rq(15, 10); idle();
        // R5: write to a non-existent index changes nothing
        wr(9, 0, 0, 0, 0); wr(6, 0, 0, 0, 0);
        rq(0, 10); rq(1, 10); rq(2, 10); rq(3, 10); rq(4, 10); rq(5, 0);
        // R6: invalidate an entry
        wr(1, 6300, 400, 0, 0); rq(1, 5); idle();
        // R2: request alongside a write to the same segment sees the old entry
        @(negedge clk);
        tbl_we = 1; tbl_idx = 4'd3; tbl_base = 16'd100; tbl_limit = 13'd50;
        tbl_share = 1; tbl_valid = 1;
        req_valid = 1; req_seg = 4'd3; req_off = 12'd10;
        rq(3, 10); rq(3, 50);
        // R1: back-to-back then idle
        rq(0, 1); rq(2, 2); idle(); idle();
        // Randomised mix of writes and requests
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            tbl_we = ($urandom % 6) == 0;
            tbl_idx = SEGNUM_W'($urandom % 8);
            tbl_base = BASE_W'($urandom);
            tbl_limit = LIM_W'($urandom % 1500);
            tbl_share = 1'($urandom);
            tbl_valid = ($urandom % 5) != 0;
            req_valid = ($urandom % 4) != 0;
            req_seg = SEGNUM_W'($urandom % 8);
            req_off = OFF_W'($urandom % 1600);
        end
        idle();
        // R9: reset mid-run empties the table
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rq(0, 0); idle(); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: act run still going exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule